// File: doc/BRIEF.md
# Two-Tier Vectored Interrupt Controller

This block takes seventeen interrupt request lines, latches each one into a pending flag, and chooses one request to hand to a CPU core. The choice is made in two steps. The sources are grouped into eight levels. A programmable rank per level decides which level wins. Inside a level, the fixed order of the sources decides. The winning source is presented as an 8-bit vector address.

When the core acknowledges, several things happen at once. Interrupts are globally disabled. A one-cycle stack-push strobe tells the core to save its program counter and flags. Sources configured for hardware clearing have their pending flag dropped. A small sequencer then reads two consecutive bytes starting at the vector address, high byte first, and joins them into the 16-bit service routine address. A return strobe from the core enables interrupts again.

Software controls the block through simple write strobes. It writes the source enables, the level enables and the level ranks, and it clears pending flags with a write-one-to-clear mask.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the following hold:
    - `irq_req` and `mem_rd` are low.
    - `svc_addr` reads 0100h.
    - Global enable is off.
    - All pending flags and enables are clear.
    - The rank of level L is L.
- R2: A source line seen high at a clock edge sets that source's pending flag. The flag stays set after the line drops.
- R3: A pending source is eligible only when three enables are set: its source enable bit (`src_en_wdata` bit = source index), its level enable bit (`lvl_en_wdata` bit = level number), and the global enable.
- R4: The vector of source i is D0h + 2·i. Sources map to levels as follows:
    - sources 0–1 → level 0
    - source 2 → level 1
    - sources 3–4 → level 2
    - sources 5–6 → level 3
    - sources 7–8 → level 4
    - sources 9–10 → level 5
    - sources 11–13 → level 6
    - sources 14–16 → level 7
- R5: Among eligible sources in one level, the lowest source index (lowest vector) wins.
- R6: Among levels with an eligible source, the one with the smallest 3-bit rank wins. The rank of level L is held in `prio_wdata[3L+2:3L]`.
- R7: When two levels carry equal ranks, the lower level number wins.
- R8: An accepted acknowledge (`irq_ack` while `irq_req` is high) has these effects:
    - Global enable is cleared.
    - `stk_push` pulses for one cycle in the following cycle.
    - The winner's pending flag is cleared only if its bit in AUTO_CLR is set (default sources 0, 2, 4, 6, 9, 11). Otherwise the flag stays pending.
- R9: A `pend_clr_we` write clears every flag whose mask bit is 1. The clear wins over a source that is high in the same cycle. The flag sets again on the next edge if the line is still high.
- R10: The cycle after an accepted acknowledge, the sequencer reads at the vector address. In the cycle after that, it reads at vector+1. In the cycle after that, `svc_done` pulses with `svc_addr` = {first byte, second byte}. `svc_addr` holds between pulses.
- R11: `irq_req` stays low while a fetch is in progress, even if global enable has been restored. A `reti` strobe sets global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 17 | Request line per source |
| src_en_we | input | 1 | Write strobe for source enables |
| src_en_wdata | input | 17 | Source enable value |
| lvl_en_we | input | 1 | Write strobe for level enables |
| lvl_en_wdata | input | 8 | Level enable value |
| prio_we | input | 1 | Write strobe for level ranks |
| prio_wdata | input | 24 | Eight 3-bit ranks |
| pend_clr_we | input | 1 | Write strobe for pending clear |
| pend_clr_mask | input | 17 | Write-one-to-clear mask |
| reti | input | 1 | Return strobe, sets global enable |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 8 | Vector of the current winner |
| irq_ack | input | 1 | Acknowledge from the core |
| mem_rd | output | 1 | Vector byte read active |
| mem_addr | output | 8 | Vector byte address |
| mem_rdata | input | 8 | Byte read back (same cycle) |
| stk_push | output | 1 | Push PC and flags strobe |
| svc_done | output | 1 | Service address valid pulse |
| svc_addr | output | 16 | Service routine address |

## Verification
The bench targets the clear-versus-set collision on a line held high. A design that let the set win would keep `irq_req` high in the cycle after the clear. A design that dropped the set would never request again.

It checks the two clearing classes side by side. A wrong mask would either re-request a hardware-cleared source after `reti` or lose a software-cleared one.

Rank ties are checked, along with reprogrammed ranks that reverse the default level order. An arbiter using the wrong comparison or the wrong field slice picks the other level.

The bench also strobes `reti` in the middle of a fetch. A design without busy gating would raise `irq_req` during the second byte read.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int NSRC   = 17;
    localparam int NLVL   = 8;
    localparam int SRC_W  = $clog2(NSRC);
    localparam int LVL_W  = $clog2(NLVL);
    localparam int RANK_W = 3;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W;
    localparam int SVC_W  = 2 * BYTE_W;
    localparam int PRIO_W = NLVL * RANK_W;

    localparam logic [ADDR_W-1:0] VEC_BASE  = 8'hD0;
    localparam logic [SVC_W-1:0]  RESET_SVC = 16'h0100;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_HI,
        SEQ_LO
    } seq_state_e;

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] src;
    } win_t;

    // Level that each source belongs to
    function automatic logic [LVL_W-1:0] src_level(input int idx);
        case (idx)
            0, 1:       return LVL_W'(0);
            2:          return LVL_W'(1);
            3, 4:       return LVL_W'(2);
            5, 6:       return LVL_W'(3);
            7, 8:       return LVL_W'(4);
            9, 10:      return LVL_W'(5);
            11, 12, 13: return LVL_W'(6);
            default:    return LVL_W'(7);
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] vec_of(input logic [SRC_W-1:0] s);
        return VEC_BASE + ADDR_W'({s, 1'b0});
    endfunction

    // Reset ranks: level L gets rank L
    function automatic logic [PRIO_W-1:0] rank_init();
        logic [PRIO_W-1:0] r;
        r = '0;
        for (int l = 0; l < NLVL; l++) begin
            r[l*RANK_W +: RANK_W] = RANK_W'(l);
        end
        return r;
    endfunction

endpackage

// File: rtl/ivc_pend.sv
module ivc_pend
    import ivc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_in,
    input  logic [NSRC-1:0] sw_clr,
    input  logic [NSRC-1:0] hw_clr,
    output logic [NSRC-1:0] pend
);

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[i] <= 1'b0;
            end else if (sw_clr[i] || hw_clr[i]) begin
                // a clear beats a same-cycle set; the line re-sets it next edge
                pend[i] <= 1'b0;
            end else if (src_in[i]) begin
                pend[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ivc_arb.sv
module ivc_arb
    import ivc_pkg::*;
(
    input  logic [NSRC-1:0]   elig,
    input  logic [PRIO_W-1:0] ranks,
    output win_t              win
);

    logic [NLVL-1:0]  lvl_hit;
    logic [SRC_W-1:0] lvl_src [NLVL];

    // Per level: fixed order, lowest source index wins
    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        logic             hit;
        logic [SRC_W-1:0] sel;

        always_comb begin
            hit = 1'b0;
            sel = '0;
            for (int i = NSRC - 1; i >= 0; i--) begin
                if (elig[i] && (src_level(i) == LVL_W'(l))) begin
                    hit = 1'b1;
                    sel = SRC_W'(i);
                end
            end
        end

        assign lvl_hit[l] = hit;
        assign lvl_src[l] = sel;
    end

    // Across levels: smallest rank, ties to the lower level (strict compare)
    always_comb begin
        logic [RANK_W-1:0] best;
        win  = '0;
        best = '1;
        for (int l = 0; l < NLVL; l++) begin
            if (lvl_hit[l] &&
                (!win.valid || (ranks[l*RANK_W +: RANK_W] < best))) begin
                win.valid = 1'b1;
                win.src   = lvl_src[l];
                best      = ranks[l*RANK_W +: RANK_W];
            end
        end
    end

endmodule

// File: rtl/ivc_seq.sv
module ivc_seq
    import ivc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_vec,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              stk_push,
    output logic              svc_done,
    output logic [SVC_W-1:0]  svc_addr
);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] vec_q;
    logic [BYTE_W-1:0] hi_q;
    logic              push_q;
    logic              done_q;
    logic [SVC_W-1:0]  svc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            vec_q   <= '0;
            hi_q    <= '0;
            push_q  <= 1'b0;
            done_q  <= 1'b0;
            svc_q   <= RESET_SVC;
        end else begin
            push_q <= 1'b0;
            done_q <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_HI;
                        vec_q   <= start_vec;
                        push_q  <= 1'b1;
                    end
                end
                SEQ_HI: begin
                    hi_q    <= mem_rdata;
                    state_q <= SEQ_LO;
                end
                SEQ_LO: begin
                    svc_q   <= {hi_q, mem_rdata};
                    done_q  <= 1'b1;
                    state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != SEQ_IDLE);
    assign mem_rd   = busy;
    assign mem_addr = (state_q == SEQ_LO) ? vec_q + ADDR_W'(1) : vec_q;
    assign stk_push = push_q;
    assign svc_done = done_q;
    assign svc_addr = svc_q;

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import ivc_pkg::*;
#(
    parameter logic [NSRC-1:0] AUTO_CLR = 17'h00A55
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   irq_src,
    input  logic              src_en_we,
    input  logic [NSRC-1:0]   src_en_wdata,
    input  logic              lvl_en_we,
    input  logic [NLVL-1:0]   lvl_en_wdata,
    input  logic              prio_we,
    input  logic [PRIO_W-1:0] prio_wdata,
    input  logic              pend_clr_we,
    input  logic [NSRC-1:0]   pend_clr_mask,
    input  logic              reti,
    output logic              irq_req,
    output logic [ADDR_W-1:0] irq_vec,
    input  logic              irq_ack,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              stk_push,
    output logic              svc_done,
    output logic [SVC_W-1:0]  svc_addr
);

    logic [NSRC-1:0]   src_en_q;
    logic [NLVL-1:0]   lvl_en_q;
    logic [PRIO_W-1:0] rank_q;
    logic              gie_q;

    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] lvl_gate;
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] sw_clr;
    logic [NSRC-1:0] hw_clr;
    win_t            win;
    logic            busy;
    logic            take;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_en_q <= '0;
            lvl_en_q <= '0;
            rank_q   <= rank_init();
            gie_q    <= 1'b0;
        end else begin
            if (src_en_we) src_en_q <= src_en_wdata;
            if (lvl_en_we) lvl_en_q <= lvl_en_wdata;
            if (prio_we)   rank_q   <= prio_wdata;
            if (take)      gie_q    <= 1'b0;
            else if (reti) gie_q    <= 1'b1;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_gate
        assign lvl_gate[i] = lvl_en_q[src_level(i)];
    end

    assign elig    = pend & src_en_q & lvl_gate & {NSRC{gie_q}};
    assign irq_req = win.valid & ~busy;
    assign irq_vec = vec_of(win.src);
    assign take    = irq_req & irq_ack;
    assign sw_clr  = pend_clr_we ? pend_clr_mask : '0;
    assign hw_clr  = take ? (AUTO_CLR & (NSRC'(1) << win.src)) : '0;

    ivc_pend u_pend (
        .clk    (clk),
        .rst    (rst),
        .src_in (irq_src),
        .sw_clr (sw_clr),
        .hw_clr (hw_clr),
        .pend   (pend)
    );

    ivc_arb u_arb (
        .elig  (elig),
        .ranks (rank_q),
        .win   (win)
    );

    ivc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (take),
        .start_vec (irq_vec),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .stk_push  (stk_push),
        .svc_done  (svc_done),
        .svc_addr  (svc_addr)
    );

endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
    import ivc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              irq_req,
    input logic              irq_ack,
    input logic [ADDR_W-1:0] irq_vec,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              stk_push,
    input logic              svc_done,
    input logic [SVC_W-1:0]  svc_addr
);

    p_vec_range_r4: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec[0] == 1'b0 && irq_vec >= 8'hD0 && irq_vec <= 8'hF0));

    p_ack_drops_req_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack) |=> (!irq_req && stk_push));

    p_push_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        stk_push |=> !stk_push);

    p_fetch_hi_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack) |=> (mem_rd && mem_addr == $past(irq_vec)));

    p_fetch_lo_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack) |=> ##1 (mem_rd && mem_addr == $past(irq_vec, 2) + 8'd1));

    p_done_after_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack) |-> ##3 svc_done);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        svc_done |=> !svc_done);

    p_svc_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !svc_done |-> $stable(svc_addr));

    p_no_req_in_fetch_r11: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> !irq_req);

endmodule

bind irq_vec_ctrl ivc_checker u_chk (.*);

// File: tb/sim_irq_vec_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vec_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [16:0] irq_src = '0;
    logic        src_en_we = 1'b0;
    logic [16:0] src_en_wdata = '0;
    logic        lvl_en_we = 1'b0;
    logic [7:0]  lvl_en_wdata = '0;
    logic        prio_we = 1'b0;
    logic [23:0] prio_wdata = '0;
    logic        pend_clr_we = 1'b0;
    logic [16:0] pend_clr_mask = '0;
    logic        reti = 1'b0;
    logic        irq_req;
    logic [7:0]  irq_vec;
    logic        irq_ack = 1'b0;
    logic        mem_rd;
    logic [7:0]  mem_addr;
    logic [7:0]  mem_rdata;
    logic        stk_push;
    logic        svc_done;
    logic [15:0] svc_addr;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];

    always #10 clk = ~clk;

    function automatic logic [7:0] mb(input logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'h3C;
    endfunction

    assign mem_rdata = mb(mem_addr);

    irq_vec_ctrl u0 (
        .clk(clk), .rst(rst), .irq_src(irq_src),
        .src_en_we(src_en_we), .src_en_wdata(src_en_wdata),
        .lvl_en_we(lvl_en_we), .lvl_en_wdata(lvl_en_wdata),
        .prio_we(prio_we), .prio_wdata(prio_wdata),
        .pend_clr_we(pend_clr_we), .pend_clr_mask(pend_clr_mask),
        .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .stk_push(stk_push), .svc_done(svc_done), .svc_addr(svc_addr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_src_en(input logic [16:0] v);
        src_en_we = 1'b1; src_en_wdata = v; tick(); src_en_we = 1'b0;
    endtask

    task automatic wr_lvl_en(input logic [7:0] v);
        lvl_en_we = 1'b1; lvl_en_wdata = v; tick(); lvl_en_we = 1'b0;
    endtask

    task automatic wr_prio(input logic [23:0] v);
        prio_we = 1'b1; prio_wdata = v; tick(); prio_we = 1'b0;
    endtask

    task automatic clr_pend(input logic [16:0] m);
        pend_clr_we = 1'b1; pend_clr_mask = m; tick(); pend_clr_we = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1; tick(); reti = 1'b0;
    endtask

    task automatic pulse_src(input logic [16:0] m);
        irq_src = m; tick(); irq_src = '0; tick();
    endtask

    task automatic expect_req(input logic [7:0] v, input string req);
        chk(irq_req === 1'b1, req, irq_req, 1);
        chk(irq_vec === v, req, irq_vec, v);
    endtask

    // Driver: acknowledge, push expected service address, follow the fetch
    task automatic service(input logic [7:0] v);
        expect_req(v, "R4");
        exp_q.push_back({mb(v), mb(v + 8'd1)});
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk(irq_req === 1'b0, "R8", irq_req, 0);
        chk(stk_push === 1'b1, "R8", stk_push, 1);
        chk(mem_rd === 1'b1 && mem_addr === v, "R10", mem_addr, v);
        tick();
        chk(stk_push === 1'b0, "R8", stk_push, 0);
        chk(mem_addr === v + 8'd1, "R10", mem_addr, v + 8'd1);
        tick();
    endtask

    // Monitor: compare each service address pulse with the scoreboard
    always @(negedge clk) begin
        if (!rst && svc_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", svc_addr, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(svc_addr === e, "R10", svc_addr, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(irq_req === 1'b0, "R1", irq_req, 0);
        chk(mem_rd === 1'b0, "R1", mem_rd, 0);
        chk(svc_addr === 16'h0100, "R1", svc_addr, 16'h0100);

        wr_src_en('1);
        wr_lvl_en('1);

        // R3 global enable gate, R2 latching
        pulse_src(17'd1 << 5);
        chk(irq_req === 1'b0, "R3", irq_req, 0);
        do_reti();
        chk(irq_req === 1'b1, "R2", irq_req, 1);
        expect_req(8'hDA, "R4");
        service(8'hDA);
        tick();
        chk(irq_req === 1'b0, "R11", irq_req, 0);
        do_reti();
        expect_req(8'hDA, "R8");       // software-cleared source still pending
        clr_pend(17'd1 << 5);
        chk(irq_req === 1'b0, "R9", irq_req, 0);

        // R8 hardware clear on acknowledge
        pulse_src(17'd1);
        service(8'hD0);
        do_reti();
        chk(irq_req === 1'b0, "R8", irq_req, 0);

        // R5 order inside a level
        pulse_src((17'd1 << 11) | (17'd1 << 12));
        expect_req(8'hE6, "R5");
        service(8'hE6);
        do_reti();
        expect_req(8'hE8, "R5");
        clr_pend(17'd1 << 12);

        // R6 and R7 order between levels
        pulse_src((17'd1 << 2) | (17'd1 << 9));
        expect_req(8'hD4, "R6");
        wr_prio(24'hFFFFFF & ~(24'h7 << 15) & ~(24'h7 << 3) | (24'h3 << 3));
        expect_req(8'hE2, "R6");
        wr_prio(24'hFFFFFF & ~(24'h7 << 15) & ~(24'h7 << 3));
        expect_req(8'hD4, "R7");

        // R3 source and level enables
        wr_lvl_en(~8'h02);
        expect_req(8'hE2, "R3");
        wr_lvl_en('1);
        wr_src_en(~(17'd1 << 2));
        expect_req(8'hE2, "R3");
        wr_src_en('1);
        clr_pend('1);
        chk(irq_req === 1'b0, "R9", irq_req, 0);

        // R9 clear against a held line
        irq_src = 17'd1 << 3;
        tick();
        expect_req(8'hD6, "R2");
        pend_clr_we = 1'b1; pend_clr_mask = 17'd1 << 3;
        tick();
        pend_clr_we = 1'b0;
        chk(irq_req === 1'b0, "R9", irq_req, 0);
        tick();
        expect_req(8'hD6, "R9");
        irq_src = '0;
        clr_pend(17'd1 << 3);

        // R11 return strobe in the middle of a fetch
        pulse_src(17'd1 << 7);
        expect_req(8'hDE, "R4");
        exp_q.push_back({mb(8'hDE), mb(8'hDF)});
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        reti = 1'b1; tick(); reti = 1'b0;
        chk(irq_req === 1'b0, "R11", irq_req, 0);
        chk(mem_addr === 8'hDF, "R10", mem_addr, 8'hDF);
        tick();
        expect_req(8'hDE, "R11");
        clr_pend(17'd1 << 7);
        repeat (3) tick();

        chk(exp_q.size() == 0, "R10", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule